// File: doc/BRIEF.md
# External Interrupt Controller Register Bank

This block gathers a parameterised number of external interrupt lines, each arriving asynchronously from a pad, and turns them into one interrupt request for a processor. Every line is resynchronised and then judged either as an edge source or as a level source. Its polarity is chosen per line. Edge events are held in a pending latch until software acknowledges them. Software can also raise or drop a pending interrupt on any line by itself. This lets a handler re-raise an edge it might have missed while it flipped polarity to emulate dual-edge detection.

Lines are packed 32 to a port word. Software reaches the controller through a flat word-addressed register interface with address, write data, write enable and combinational read data. Each per-line attribute has a pair of write-one registers, one that sets bits and one that clears them, so one line can be changed without a read-modify-write. A per-line routing enable must be set before a line can reach the request output. The request is the OR of every line that is routed, unmasked and active. Software reads the status word for a port and services the lowest set bit first.

Top module: `eint_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every implemented line is masked (mask reads 1), edge-sensitive (0), falling/low polarity (0), routing-disabled (0), and has no edge or software pending. `irq` is low.
- R2: Byte address bits [9:6] select a register group and bits [5:2] select the port, at a 4-byte stride. Line n is bit n mod 32 of port n/32. Bits of lines that do not exist, and ports beyond the last one, read 0 and cannot be set. Groups 2, 3, 5, 6, 8, 9, 10, 12 and 13 are write-only and read 0.
- R3: Group 1 reads the mask, where 1 means blocked. Writing 1s to group 2 sets mask bits and writing 1s to group 3 clears them. Written 0s leave bits unchanged.
- R4: Group 4 reads the sensitivity, where 1 means level and 0 means edge. Group 5 sets bits and group 6 clears them, both write-one.
- R5: Group 7 reads the polarity, where 1 means active-high or rising and 0 means active-low or falling. Group 8 sets bits and group 9 clears them, both write-one.
- R6: Every input passes through two flip-flops. A change first sampled at clock edge k is seen as a level from edge k+1 and is latched as an edge event at edge k+2.
- R7: In edge mode, a transition in the selected direction sets the line's edge-pending bit whatever its mask or routing. Group 15 reads the edge-pending bits. A write-one to group 10 clears them. If an acknowledge and a new edge on the same line fall in the same cycle, the bit stays set.
- R8: Group 11 reads the software-pending bits. A write-one to group 12 sets them and a write-one to group 13 clears them.
- R9: Group 14 is a plain read/write routing-enable word per port. A line can only contribute to status when its bit is 1.
- R10: A status bit (group 0) is 1 when the line has an edge pending, or is level-sensitive with its synchronised input equal to its polarity bit, or has a software pending bit, and it is also routed and unmasked. `irq` is the combinational OR of all status bits.
- R11: Switching a line between edge and level mode leaves its edge-pending bit unchanged. In level mode, an acknowledge does not remove a level that is still active.
- R12: Writes to the read-only groups 0, 1, 4, 7, 11 and 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | NUM_CH | Asynchronous external interrupt lines |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write enable, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Combined interrupt request |

## Verification
Two collisions matter most. An acknowledge write can land on the same clock as a fresh edge on that line, and a mask or polarity write can land on the same clock as an input transition. The bench forces the first on purpose by timing an acknowledge against the two-stage input pipeline so that both reach the pending latch together, and expects the bit to remain set. Long random runs mix input toggles with writes to every group and port, so mask, sensitivity and software writes meet input events in the same cycle. On every clock the bench compares `irq` and the word read at the current address against a per-line behavioural model.

// File: rtl/eint_pkg.sv
// Shared definitions for the external interrupt controller.
// Assumes 32-bit register words and a 4-bit register group field at the top of the address.
package eint_pkg;

    localparam int WORD_W = 32;
    localparam int GRP_W  = 4;

    // Register groups, selected by the upper address bits.
    typedef enum logic [GRP_W-1:0] {
        GRP_STATUS   = 4'd0,
        GRP_MASK     = 4'd1,
        GRP_MASK_SET = 4'd2,
        GRP_MASK_CLR = 4'd3,
        GRP_SENS     = 4'd4,
        GRP_SENS_SET = 4'd5,
        GRP_SENS_CLR = 4'd6,
        GRP_POL      = 4'd7,
        GRP_POL_SET  = 4'd8,
        GRP_POL_CLR  = 4'd9,
        GRP_ACK      = 4'd10,
        GRP_SOFT     = 4'd11,
        GRP_SOFT_SET = 4'd12,
        GRP_SOFT_CLR = 4'd13,
        GRP_ROUTE    = 4'd14,
        GRP_EDGE     = 4'd15
    } grp_e;

    // Per-port write strobes produced by the address decoder.
    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic sens_set;
        logic sens_clr;
        logic pol_set;
        logic pol_clr;
        logic ack;
        logic soft_set;
        logic soft_clr;
        logic route_wr;
    } port_wr_t;

    // Bits of a port word that correspond to real lines.
    function automatic logic [WORD_W-1:0] valid_bits(input int n);
        if (n >= WORD_W) return '1;
        return (32'h1 << n) - 32'h1;
    endfunction

    // Write-one-to-set / write-one-to-clear update of one port word.
    function automatic logic [WORD_W-1:0] w1_apply(
        input logic [WORD_W-1:0] cur,
        input logic              set_en,
        input logic              clr_en,
        input logic [WORD_W-1:0] data,
        input logic [WORD_W-1:0] valid
    );
        logic [WORD_W-1:0] nxt;
        nxt = cur;
        if (set_en) nxt = cur | data;
        if (clr_en) nxt = cur & ~data;
        return nxt & valid;
    endfunction

endpackage

// File: rtl/eint_sync.sv
// Two-stage resynchroniser for a bus of independent asynchronous lines.
// Assumes each line is a slow, independent level; no multi-bit coherency is implied.
module eint_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two flops in series to settle metastability before any detection logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/eint_port.sv
// One 32-line port: configuration words, edge detection, pending latches and status.
// Assumes sync_in is already resynchronised; lines at or above CH_IN_PORT are tied off.
module eint_port
    import eint_pkg::*;
#(
    parameter int CH_IN_PORT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] sync_in,
    input  port_wr_t          wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] mask_q,
    output logic [WORD_W-1:0] sens_q,
    output logic [WORD_W-1:0] pol_q,
    output logic [WORD_W-1:0] soft_q,
    output logic [WORD_W-1:0] route_q,
    output logic [WORD_W-1:0] edge_q,
    output logic [WORD_W-1:0] status
);

    localparam logic [WORD_W-1:0] VALID = valid_bits(CH_IN_PORT);

    logic [WORD_W-1:0] prev_q;
    logic [WORD_W-1:0] rise;
    logic [WORD_W-1:0] fall;
    logic [WORD_W-1:0] hit;
    logic [WORD_W-1:0] lvl_on;
    logic [WORD_W-1:0] ack_bits;

    // Edge and level qualification against the selected polarity.
    always_comb begin
        rise     = sync_in & ~prev_q;
        fall     = ~sync_in & prev_q;
        hit      = ((pol_q & rise) | (~pol_q & fall)) & ~sens_q & VALID;
        lvl_on   = sens_q & ~(sync_in ^ pol_q);
        ack_bits = wr.ack ? wdata : '0;
    end

    // Status word: any active source, gated by routing and mask.
    always_comb begin
        status = (edge_q | lvl_on | soft_q) & route_q & ~mask_q & VALID;
    end

    // Previous synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in & VALID;
    end

    // Mask word: reset blocks every real line.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= VALID;
        else        mask_q <= w1_apply(mask_q, wr.mask_set, wr.mask_clr, wdata, VALID);
    end

    // Sensitivity word: reset selects edge mode.
    always_ff @(posedge clk) begin
        if (!rst_n) sens_q <= '0;
        else        sens_q <= w1_apply(sens_q, wr.sens_set, wr.sens_clr, wdata, VALID);
    end

    // Polarity word: reset selects low level / falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pol_q <= '0;
        else        pol_q <= w1_apply(pol_q, wr.pol_set, wr.pol_clr, wdata, VALID);
    end

    // Software-raised pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_q <= '0;
        else        soft_q <= w1_apply(soft_q, wr.soft_set, wr.soft_clr, wdata, VALID);
    end

    // Routing enable: plain read/write word.
    always_ff @(posedge clk) begin
        if (!rst_n)           route_q <= '0;
        else if (wr.route_wr) route_q <= wdata & VALID;
    end

    // Edge pending: a new edge wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= ((edge_q & ~ack_bits) | hit) & VALID;
    end

endmodule

// File: rtl/eint_regif.sv
// Register address decoder and read multiplexer for all ports.
// Assumes word-aligned accesses; address bits [1:0] are ignored.
module eint_regif
    import eint_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_we,
    input  logic [NPORTS*WORD_W-1:0] status_flat,
    input  logic [NPORTS*WORD_W-1:0] mask_flat,
    input  logic [NPORTS*WORD_W-1:0] sens_flat,
    input  logic [NPORTS*WORD_W-1:0] pol_flat,
    input  logic [NPORTS*WORD_W-1:0] soft_flat,
    input  logic [NPORTS*WORD_W-1:0] route_flat,
    input  logic [NPORTS*WORD_W-1:0] edge_flat,
    output port_wr_t [NPORTS-1:0]    wr_vec,
    output logic [WORD_W-1:0]        reg_rdata
);

    localparam int PB = ADDR_W - GRP_W - 2;

    logic [GRP_W-1:0] grp;
    logic [PB-1:0]    pidx;
    logic             unused_low;

    assign grp        = reg_addr[ADDR_W-1 -: GRP_W];
    assign pidx       = reg_addr[ADDR_W-GRP_W-1:2];
    assign unused_low = ^reg_addr[1:0];

    // Per-port write strobes from group and port fields.
    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            wr_vec[p] = '0;
            if (reg_we && int'(pidx) == p) begin
                wr_vec[p].mask_set = (grp == GRP_MASK_SET);
                wr_vec[p].mask_clr = (grp == GRP_MASK_CLR);
                wr_vec[p].sens_set = (grp == GRP_SENS_SET);
                wr_vec[p].sens_clr = (grp == GRP_SENS_CLR);
                wr_vec[p].pol_set  = (grp == GRP_POL_SET);
                wr_vec[p].pol_clr  = (grp == GRP_POL_CLR);
                wr_vec[p].ack      = (grp == GRP_ACK);
                wr_vec[p].soft_set = (grp == GRP_SOFT_SET);
                wr_vec[p].soft_clr = (grp == GRP_SOFT_CLR);
                wr_vec[p].route_wr = (grp == GRP_ROUTE);
            end
        end
    end

    // Read multiplexer: readable groups only, absent ports read zero.
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (int'(pidx) == p) begin
                case (grp)
                    GRP_STATUS: reg_rdata = status_flat[p*WORD_W +: WORD_W];
                    GRP_MASK:   reg_rdata = mask_flat[p*WORD_W +: WORD_W];
                    GRP_SENS:   reg_rdata = sens_flat[p*WORD_W +: WORD_W];
                    GRP_POL:    reg_rdata = pol_flat[p*WORD_W +: WORD_W];
                    GRP_SOFT:   reg_rdata = soft_flat[p*WORD_W +: WORD_W];
                    GRP_ROUTE:  reg_rdata = route_flat[p*WORD_W +: WORD_W];
                    GRP_EDGE:   reg_rdata = edge_flat[p*WORD_W +: WORD_W];
                    default:    reg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/eint_ctrl.sv
// External interrupt controller top: resynchronises the lines, instantiates one
// port slice per 32 lines, decodes register accesses and ORs the status into irq.
// Assumes NUM_CH fits in the port field: ceil(NUM_CH/32) <= 2**(ADDR_W-6).
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int NUM_CH = 40,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ext_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int NPORTS = (NUM_CH + WORD_W - 1) / WORD_W;
    localparam int FLAT_W = NPORTS * WORD_W;

    logic [NUM_CH-1:0]    sync_ch;
    logic [FLAT_W-1:0]    sync_flat;
    logic [FLAT_W-1:0]    status_flat;
    logic [FLAT_W-1:0]    mask_flat;
    logic [FLAT_W-1:0]    sens_flat;
    logic [FLAT_W-1:0]    pol_flat;
    logic [FLAT_W-1:0]    soft_flat;
    logic [FLAT_W-1:0]    route_flat;
    logic [FLAT_W-1:0]    edge_flat;
    port_wr_t [NPORTS-1:0] wr_vec;

    eint_sync #(.WIDTH(NUM_CH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .sync_out (sync_ch)
    );

    // Pad the synchronised lines out to whole port words.
    always_comb begin
        sync_flat               = '0;
        sync_flat[NUM_CH-1:0]   = sync_ch;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int CHP = ((NUM_CH - p*WORD_W) >= WORD_W) ? WORD_W : (NUM_CH - p*WORD_W);
        eint_port #(.CH_IN_PORT(CHP)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_flat[p*WORD_W +: WORD_W]),
            .wr      (wr_vec[p]),
            .wdata   (reg_wdata),
            .mask_q  (mask_flat[p*WORD_W +: WORD_W]),
            .sens_q  (sens_flat[p*WORD_W +: WORD_W]),
            .pol_q   (pol_flat[p*WORD_W +: WORD_W]),
            .soft_q  (soft_flat[p*WORD_W +: WORD_W]),
            .route_q (route_flat[p*WORD_W +: WORD_W]),
            .edge_q  (edge_flat[p*WORD_W +: WORD_W]),
            .status  (status_flat[p*WORD_W +: WORD_W])
        );
    end

    eint_regif #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_regif (
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .status_flat (status_flat),
        .mask_flat   (mask_flat),
        .sens_flat   (sens_flat),
        .pol_flat    (pol_flat),
        .soft_flat   (soft_flat),
        .route_flat  (route_flat),
        .edge_flat   (edge_flat),
        .wr_vec      (wr_vec),
        .reg_rdata   (reg_rdata)
    );

    // Combined request to the processor.
    assign irq = |status_flat;

endmodule

// File: rtl/eint_ctrl_chk.sv
// Property checker for eint_ctrl, attached by bind. Decodes register accesses
// independently of the design and relates them to the per-port state over time.
module eint_ctrl_chk
    import eint_pkg::*;
#(
    parameter int NUM_CH = 40,
    parameter int ADDR_W = 10
) (
    input logic                                                  clk,
    input logic                                                  rst_n,
    input logic [ADDR_W-1:0]                                     reg_addr,
    input logic                                                  reg_we,
    input logic [WORD_W-1:0]                                     reg_wdata,
    input logic                                                  irq,
    input logic [((NUM_CH+WORD_W-1)/WORD_W)*WORD_W-1:0]          status_flat,
    input logic [((NUM_CH+WORD_W-1)/WORD_W)*WORD_W-1:0]          edge_flat,
    input logic [((NUM_CH+WORD_W-1)/WORD_W)*WORD_W-1:0]          soft_flat,
    input logic [((NUM_CH+WORD_W-1)/WORD_W)*WORD_W-1:0]          sync_flat,
    input logic [((NUM_CH+WORD_W-1)/WORD_W)*WORD_W-1:0]          mask_flat,
    input logic [((NUM_CH+WORD_W-1)/WORD_W)*WORD_W-1:0]          sens_flat,
    input logic [((NUM_CH+WORD_W-1)/WORD_W)*WORD_W-1:0]          pol_flat,
    input logic [((NUM_CH+WORD_W-1)/WORD_W)*WORD_W-1:0]          route_flat
);

    localparam int NPORTS = (NUM_CH + WORD_W - 1) / WORD_W;
    localparam int FLAT_W = NPORTS * WORD_W;

    logic [GRP_W-1:0]          grp;
    logic [ADDR_W-GRP_W-3:0]   pidx;
    logic                      unused_low;
    logic [FLAT_W-1:0]         sync_d;

    assign grp        = reg_addr[ADDR_W-1 -: GRP_W];
    assign pidx       = reg_addr[ADDR_W-GRP_W-1:2];
    assign unused_low = ^reg_addr[1:0];

    // Checker copy of last cycle's synchronised lines.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_d <= '0;
        else        sync_d <= sync_flat;
    end

    // R1: the cycle after reset the request is low.
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !irq);

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        localparam int CHP = ((NUM_CH - p*WORD_W) >= WORD_W) ? WORD_W : (NUM_CH - p*WORD_W);
        localparam logic [WORD_W-1:0] VP = valid_bits(CHP);

        // R3: masking a whole port silences its status next cycle.
        a_r3_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && grp == GRP_MASK_SET && int'(pidx) == p && reg_wdata == '1)
            |=> (status_flat[p*WORD_W +: WORD_W] == '0));

        // R7: acknowledged bits are clear unless an input changed that cycle.
        a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && grp == GRP_ACK && int'(pidx) == p)
            |=> ((edge_flat[p*WORD_W +: WORD_W] & $past(reg_wdata)
                  & ~($past(sync_flat[p*WORD_W +: WORD_W]) ^ $past(sync_d[p*WORD_W +: WORD_W]))) == '0));

        // R7: an edge-pending bit only drops after an acknowledge to its port.
        a_r7_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (|($past(edge_flat[p*WORD_W +: WORD_W]) & ~edge_flat[p*WORD_W +: WORD_W]))
            |-> $past(reg_we && grp == GRP_ACK && int'(pidx) == p));

        // R8: software set raises every written real line.
        a_r8_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && grp == GRP_SOFT_SET && int'(pidx) == p)
            |=> ((soft_flat[p*WORD_W +: WORD_W] & $past(reg_wdata) & VP) == ($past(reg_wdata) & VP)));

        // R10: an active, routed, unmasked level line always shows in status.
        a_r10_level_shows: assert property (@(posedge clk) disable iff (!rst_n)
            ((sens_flat[p*WORD_W +: WORD_W] & ~mask_flat[p*WORD_W +: WORD_W]
              & route_flat[p*WORD_W +: WORD_W]
              & ~(sync_flat[p*WORD_W +: WORD_W] ^ pol_flat[p*WORD_W +: WORD_W])
              & VP & ~status_flat[p*WORD_W +: WORD_W]) == '0));
    end

endmodule

bind eint_ctrl eint_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .irq         (irq),
    .status_flat (status_flat),
    .edge_flat   (edge_flat),
    .soft_flat   (soft_flat),
    .sync_flat   (sync_flat),
    .mask_flat   (mask_flat),
    .sens_flat   (sens_flat),
    .pol_flat    (pol_flat),
    .route_flat  (route_flat)
);

// File: tb/eint_ctrl_bench.sv
// Self-checking bench: a per-line behavioural model is compared with irq and the
// read data on every clock, plus directed checks of timing and collision cases.
module eint_ctrl_bench;

    localparam int NCH = 40;
    localparam int AW  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  ext = '0;
    logic [AW-1:0]   addr = '0;
    logic            we = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    eint_ctrl #(.NUM_CH(NCH), .ADDR_W(AW)) u_eint_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (ext),
        .reg_addr  (addr),
        .reg_we    (we),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq       (irq)
    );

    // Behavioural model, one bit per line.
    bit [NCH-1:0] m_s1, m_s2, m_prev, m_mask, m_sens, m_pol, m_soft, m_dom, m_edge, m_status;
    bit m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
            m_mask <= '1; m_sens <= '0; m_pol <= '0;
            m_soft <= '0; m_dom <= '0; m_edge <= '0;
        end else begin
            m_s1 <= ext; m_s2 <= m_s1; m_prev <= m_s2;
            for (int c = 0; c < NCH; c++) begin
                automatic int  g   = int'(addr[9:6]);
                automatic bit  mine = we && (int'(addr[5:2]) == c / 32);
                automatic bit  sel = mine && wdata[c % 32];
                automatic bit  hit = m_pol[c] ? (m_s2[c] && !m_prev[c]) : (!m_s2[c] && m_prev[c]);
                if (sel && g == 2)  m_mask[c] <= 1'b1;
                if (sel && g == 3)  m_mask[c] <= 1'b0;
                if (sel && g == 5)  m_sens[c] <= 1'b1;
                if (sel && g == 6)  m_sens[c] <= 1'b0;
                if (sel && g == 8)  m_pol[c]  <= 1'b1;
                if (sel && g == 9)  m_pol[c]  <= 1'b0;
                if (sel && g == 12) m_soft[c] <= 1'b1;
                if (sel && g == 13) m_soft[c] <= 1'b0;
                if (mine && g == 14) m_dom[c] <= wdata[c % 32];
                if (!m_sens[c] && hit)     m_edge[c] <= 1'b1;
                else if (sel && g == 10)   m_edge[c] <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++)
            m_status[c] = (m_edge[c] || (m_sens[c] && (m_s2[c] == m_pol[c])) || m_soft[c])
                          && m_dom[c] && !m_mask[c];
        m_irq = |m_status;
    end

    function automatic logic [31:0] m_read(input logic [AW-1:0] a);
        logic [31:0] r = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(a[5:2]) == c / 32) begin
                case (int'(a[9:6]))
                    0:  r[c % 32] = m_status[c];
                    1:  r[c % 32] = m_mask[c];
                    4:  r[c % 32] = m_sens[c];
                    7:  r[c % 32] = m_pol[c];
                    11: r[c % 32] = m_soft[c];
                    14: r[c % 32] = m_dom[c];
                    15: r[c % 32] = m_edge[c];
                    default: r[c % 32] = 1'b0;
                endcase
            end
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [AW-1:0] a);
        if (int'(a[5:2]) >= 2) return "R2";
        case (int'(a[9:6]))
            0:          return "R10";
            1, 2, 3:    return "R3";
            4, 5, 6:    return "R4";
            7, 8, 9:    return "R5";
            10, 15:     return "R7";
            11, 12, 13: return "R8";
            default:    return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R10", {31'b0, irq}, {31'b0, m_irq});
            chk(tag_of(addr), rdata, m_read(addr));
        end
    end

    function automatic logic [AW-1:0] A(input int g, input int p);
        return {4'(g), 4'(p), 2'b00};
    endfunction

    task automatic wr(input int g, input int p, input logic [31:0] d);
        @(posedge clk); #2;
        we = 1'b1; addr = A(g, p); wdata = d;
        @(posedge clk); #2;
        we = 1'b0;
    endtask

    task automatic expect_read(input int g, input int p, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        we = 1'b0; addr = A(g, p);
        @(negedge clk);
        chk(tag, rdata, exp);
    endtask

    task automatic expect_irq(input logic exp, input string tag);
        @(negedge clk);
        chk(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #5_000_000;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1: reset state.
        expect_read(1, 0, 32'hFFFF_FFFF, "R1");
        expect_read(1, 1, 32'h0000_00FF, "R1");
        expect_read(4, 0, 32'h0, "R1");
        expect_read(7, 0, 32'h0, "R1");
        expect_read(14, 0, 32'h0, "R1");
        expect_read(15, 0, 32'h0, "R1");
        expect_irq(1'b0, "R1");

        // Setup line 5: routed, rising edge, unmasked.
        wr(14, 0, 32'hFFFF_FFFF);
        wr(14, 1, 32'hFFFF_FFFF);
        wr(8, 0, 32'h20);
        wr(3, 0, 32'h20);
        expect_read(7, 0, 32'h20, "R5");
        expect_read(1, 0, 32'hFFFF_FFDF, "R3");

        // R6: pipeline latency of an edge.
        @(posedge clk); #2; ext[5] = 1'b1;
        expect_irq(1'b0, "R6");
        expect_irq(1'b0, "R6");
        expect_irq(1'b0, "R6");
        expect_irq(1'b1, "R6");
        expect_read(15, 0, 32'h20, "R7");

        // R11: switch to level keeps the pending edge; ack leaves the level active.
        wr(5, 0, 32'h20);
        expect_read(15, 0, 32'h20, "R11");
        wr(10, 0, 32'h20);
        expect_read(15, 0, 32'h0, "R7");
        expect_irq(1'b1, "R11");

        // R7: acknowledge and new edge in the same cycle.
        wr(6, 0, 32'h20);
        @(posedge clk); #2; ext[5] = 1'b0;
        idle(4);
        wr(10, 0, 32'h20);
        @(posedge clk); #2; ext[5] = 1'b1;
        @(posedge clk);
        @(posedge clk); #2;
        we = 1'b1; addr = A(10, 0); wdata = 32'h20;
        @(posedge clk); #2;
        we = 1'b0;
        expect_read(15, 0, 32'h20, "R7");

        // R12: writes to read-only groups change nothing.
        wr(1, 0, 32'h0);
        expect_read(1, 0, 32'hFFFF_FFDF, "R12");
        wr(11, 0, 32'hFFFF_FFFF);
        expect_read(11, 0, 32'h0, "R12");
        wr(15, 0, 32'h0);
        expect_read(15, 0, 32'h20, "R12");

        // R8: software set/clear on line 39.
        wr(3, 1, 32'h80);
        wr(12, 1, 32'h80);
        expect_read(0, 1, 32'h80, "R8");
        wr(13, 1, 32'h80);
        expect_read(0, 1, 32'h0, "R8");

        // R2: nonexistent line and port.
        wr(12, 1, 32'h100);
        expect_read(11, 1, 32'h0, "R2");
        wr(14, 2, 32'hFFFF_FFFF);
        expect_read(14, 2, 32'h0, "R2");

        // R9: routing disable removes a soft source.
        wr(12, 1, 32'h80);
        wr(14, 1, 32'h0);
        expect_read(0, 1, 32'h0, "R9");

        // Random mix of input toggles and writes.
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #2;
            if ($urandom % 3 == 0) ext[$urandom % NCH] ^= 1'b1;
            we    = ($urandom % 2) == 1;
            addr  = {4'($urandom), 4'($urandom % 3), 2'b00};
            wdata = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
        end
        @(posedge clk); #2;
        we = 1'b0;
        idle(3);

        summary();
        $finish;
    end

endmodule